// File: doc/BRIEF.md
# Serial Byte Receiver with Start-Bit Glitch Filter

This block recovers bytes from an asynchronous serial line. A fast system clock oversamples the line, and a fixed number of clocks per bit is derived from two parameters: the system clock rate and the line rate. By default these are 50 MHz and 57600 bit/s, which gives 868 clocks per bit. The line input is synchronised and then watched for a falling edge.

A falling edge opens a qualification window. If the line goes high again before 80% of a bit period has passed, the edge is treated as noise and the receiver returns to idle. After the 80% mark a hold latch is set, and from then on nothing on the line cancels the frame. At one full bit period the receiver starts collecting data. It samples eight data bits at the middle of their slots, least significant bit first. It then sits out a fixed stop phase of two bit periods without looking at the line.

Each completed byte is presented on a parallel output together with a one-cycle strobe. The byte stays on the output until the next strobe.

Top module: `uart_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `valid_o` is 0 and `data_o` is 0x00. A frame sent after release is received normally.
- R2: A frame is one low start bit, eight data bits with the first transmitted bit landing in `data_o[0]`, and a high stop level. For every byte value, `data_o` after the strobe equals the byte that was sent.
- R3: `valid_o` is high for exactly one clock per frame. It rises 9*C+3 clocks after the clock edge that first registers the line's fall, where C = CLK_HZ/BAUD. The +3 covers the two synchroniser stages and the edge register.
- R4: A low pulse on the line lasting H = floor(4*C/5) clocks or fewer produces no strobe and returns the receiver to idle. A frame sent afterwards is received correctly.
- R5: A low pulse lasting H+1 clocks or more is accepted as a start bit even if the line then stays high. The result is a strobe with `data_o` = 0xFF.
- R6: Data bit k is sampled C + C/2 + k*C clocks after the line falls. A bit driven correctly only in a 5-clock window centred on that point is still received correctly.
- R7: After the last data bit the receiver ignores the line for 2*C clocks. A low pulse of a full bit length inside that phase produces no strobe.
- R8: `data_o` holds its value between strobes, including while glitches and ignored pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Serial line, idles high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe marking a new byte on `data_o` |

## Verification
The assertions assume that the line idles high before each frame. They also assume that no new start edge is sent until the stop phase has finished, that is, 11 bit periods after the previous fall. Under these conditions the strobe, the abort path and the stop phase follow one fixed sequence.

The stimulus honours this by leaving at least three bit periods of high line after every frame or glitch. The one deliberate exception is the pulse placed inside the stop phase, and that pulse returns high before the phase ends. The bench runs at 16 clocks per bit, so it can sweep every byte value and every glitch length from 1 to 16 clocks.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  localparam int unsigned DATA_BITS = 8;
endpackage

// File: rtl/uart_rx_rst_sync.sv
module uart_rx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/uart_rx_line_sync.sv
module uart_rx_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_o = sync_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 868
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  input  logic                 fall_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  localparam int unsigned HOLD_CLKS = (CLKS_PER_BIT * 4) / 5;
  localparam int unsigned HALF_CLKS = CLKS_PER_BIT / 2;
  localparam int unsigned STOP_CLKS = 2 * CLKS_PER_BIT;
  localparam int unsigned CW        = $clog2(STOP_CLKS + 1);
  localparam int unsigned BW        = $clog2(DATA_BITS);

  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CLKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CLKS - 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_CLKS - 1);
  localparam logic [BW-1:0] IDX_LAST  = BW'(DATA_BITS - 1);

  rx_state_t            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 hold_q, hold_d;
  logic [BW-1:0]        idx_q, idx_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 sample_en, shift_en, data_en;

  assign sample_en = (state_q == ST_DATA) && (cnt_q == HALF_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hold_d  = hold_q;
    idx_d   = idx_q;
    data_en = 1'b0;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d  = '0;
        hold_d = 1'b0;
        idx_d  = '0;
        if (fall_i) state_d = ST_START;
      end
      ST_START: begin
        cnt_d = cnt_q + 1'b1;
        if (!hold_q && line_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          if (cnt_q == HOLD_LAST) hold_d = 1'b1;
          if (cnt_q == BIT_LAST) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            hold_d  = 1'b0;
          end
        end
      end
      ST_DATA: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == BIT_LAST) begin
          cnt_d = '0;
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            state_d = ST_STOP;
            data_en = 1'b1;
            valid_d = 1'b1;
          end
        end
      end
      ST_STOP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == STOP_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign shift_en = sample_en;
  assign shift_d  = {line_i, shift_q[DATA_BITS-1:1]};
  assign data_d   = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R3: the strobe lasts a single clock
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R3: the strobe only appears on entry to the stop phase
  a_r3_strobe_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (state_q == ST_STOP) && (cnt_q == '0));

  // R4: line back high before the hold latch is set aborts the start
  a_r4_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && !hold_q && line_i) |=> (state_q == ST_IDLE));

  // R5: once latched, the start phase cannot fall back to idle
  a_r5_hold_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && hold_q) |=> (state_q != ST_IDLE));

  // R5: the hold latch lives only inside the start phase
  a_r5_hold_scope: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (state_q == ST_START));

  // R7: the stop phase runs to its end whatever the line does
  a_r7_stop_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && cnt_q != STOP_LAST) |=> (state_q == ST_STOP));

  // R8: the output byte only moves with a strobe
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_d |=> $stable(data_q));
endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 57_600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  localparam int unsigned CLKS_PER_BIT = CLK_HZ / BAUD;

  logic rst_sync_n;
  logic line;
  logic fall;

  uart_rx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_rx_line_sync u_line (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall)
  );

  uart_rx_ctrl #(
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .line_i  (line),
    .fall_i  (fall),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/uart_rx_tb.sv
`timescale 1ns/1ps
module uart_rx_tb;
  localparam int C    = 16;
  localparam int HOLD = (C * 4) / 5;
  localparam int HALF = C / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] data;
  logic       valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nvalid = 0;
  int last_cyc = 0;
  logic prev_valid = 1'b0;
  logic [7:0] last_data = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx #(.CLK_HZ(C), .BAUD(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .data_o(data), .valid_o(valid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (valid) begin
      nvalid    = nvalid + 1;
      last_cyc  = cyc;
      last_data = data;
    end
    if (rst_n && valid && prev_valid) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL R3 strobe wider than one clock: actual 2+ expected 1");
    end
    prev_valid = valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit narrow, output int t0);
    @(negedge clk);
    t0 = cyc;
    drive(1'b0, C);
    for (int i = 0; i < 8; i++) begin
      if (narrow) begin
        drive(~b[i], HALF - 2);
        drive(b[i], 5);
        drive(~b[i], C - HALF - 3);
      end else begin
        drive(b[i], C);
      end
    end
    drive(1'b1, 3 * C);
  endtask

  task automatic expect_frame(input logic [7:0] b, input bit narrow, input string req);
    int t0;
    int n0;
    n0 = nvalid;
    send_byte(b, narrow, t0);
    check(nvalid == n0 + 1, req, nvalid - n0, 1);
    check(last_data == b, req, last_data, b);
    check(last_cyc - t0 == 9 * C + 3, "R3 latency", last_cyc - t0, 9 * C + 3);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [7:0] held;
    repeat (5) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", valid, 0);
    check(data == 8'h00, "R1 data in reset", data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid == 1'b0, "R1 valid after release", valid, 0);
    check(data == 8'h00, "R1 data after release", data, 0);
    expect_frame(8'h96, 1'b0, "R1 first frame");

    // R2 / R3: every byte value
    for (int b = 0; b < 256; b++) expect_frame(8'(b), 1'b0, "R2 byte");

    // R6: bits only valid near the slot middle
    for (int k = 0; k < 16; k++) expect_frame(8'(k * 17 + 3), 1'b1, "R6 midpoint");

    // R4: short lows are dropped, R8 data held
    for (int len = 1; len <= HOLD; len++) begin
      held = data;
      n0 = nvalid;
      @(negedge clk);
      drive(1'b0, len);
      drive(1'b1, 12 * C);
      check(nvalid == n0, "R4 glitch dropped", nvalid - n0, 0);
      check(data == held, "R8 data held", data, held);
    end
    expect_frame(8'h3C, 1'b0, "R4 recovery");

    // R5: long enough lows are latched
    for (int len = HOLD + 1; len <= C; len++) begin
      n0 = nvalid;
      @(negedge clk);
      drive(1'b0, len);
      drive(1'b1, 12 * C);
      check(nvalid == n0 + 1, "R5 accepted", nvalid - n0, 1);
      check(last_data == 8'hFF, "R5 all ones", last_data, 8'hFF);
    end

    // R7: pulse inside the stop phase ignored
    n0 = nvalid;
    @(negedge clk);
    drive(1'b0, C);
    for (int i = 0; i < 8; i++) drive(i[0], C);
    drive(1'b1, 4);
    drive(1'b0, C);
    drive(1'b1, 14 * C);
    check(nvalid == n0 + 1, "R7 one frame only", nvalid - n0, 1);
    check(data == 8'hAA, "R7 data kept", data, 8'hAA);
    expect_frame(8'h5A, 1'b0, "R7 recovery");

    // R1: reset mid-frame
    @(negedge clk);
    drive(1'b0, C);
    drive(1'b1, 2 * C);
    rst_n = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R1 mid-frame reset valid", valid, 0);
    check(data == 8'h00, "R1 mid-frame reset data", data, 0);
    rst_n = 1'b1;
    drive(1'b1, 12 * C);
    expect_frame(8'hC3, 1'b0, "R1 after mid-frame reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule